// File: doc/BRIEF.md
# Snoop Invalidate Issue Scheduler

This block sits between a watcher on the system bus and the processor's external snoop port. Each memory write by another bus master is reduced to its line address and queued. The block then presents the queued addresses one at a time to the processor. Each one goes out as an active-low strobe, one clock wide, with the address valid in that same clock. The pacing obeys the processor's restriction around the final ready of a transfer: it must be able to see the strobe inactive either in that clock or in the clock after it.

Two pacing modes exist, and the mode pin is captured only while reset is held. The alternating mode ignores all bus activity and never strobes in two adjacent clocks. The tracked mode watches the normal ready, burst ready and burst-last lines. It strobes every clock, except that it holds the strobe inactive in the clock after a detected final ready.

The block also records the line of a cacheable read fill that the processor has started. A write by another master into that line while the fill is open is put at the head of the queue. The processor then invalidates the line it is filling instead of keeping stale data.

Top module: `snoop_inval_sched`

## Requirements
- R1: While reset is held, `snoop_stb_n_o` is 1 and `wr_ready_n_o` is 0, the queue is emptied, and the level of `mode_track_i` is captured (0 = alternating mode, 1 = tracked mode).
- R2: Every accepted write produces exactly one strobe clock (`snoop_stb_n_o` = 0). During that clock `snoop_addr_o` carries the write address with bits [3:0] cleared. Writes are issued in arrival order unless R8 applies.
- R3: In alternating mode `snoop_stb_n_o` is never 0 in two consecutive clocks. The ready, burst-ready and burst-last inputs have no effect on when the strobe goes low.
- R4: In tracked mode, a non-empty queue with no final ready present issues one address per clock, in back-to-back clocks.
- R5: A final ready is either `xfer_done_n_i` = 0 or both `burst_done_n_i` = 0 and `burst_end_n_i` = 0 in the same clock. In tracked mode, the strobe is 1 in the clock after a final ready. A burst ready with `burst_end_n_i` = 1 does not hold the strobe back.
- R6: The queue holds 4 line addresses. `wr_ready_n_o` is 1 while 4 are held, and a write offered while the queue is full is discarded.
- R7: A fill opens when `fill_start_i` = 1 with `fill_cacheable_i` = 1. The line of `fill_addr_i` is recorded, and the fill closes on a final ready. A start with `fill_cacheable_i` = 0 opens no fill, and a start wins over a final ready in the same clock.
- R8: A write whose address matches the open fill's line (bits [3:0] ignored) is placed at the head of the queue, ahead of older entries.
- R9: A change of `mode_track_i` after reset has been released has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_track_i | input | 1 | Mode select captured during reset: 1 = tracked, 0 = alternating |
| wr_valid_i | input | 1 | A write by another master has been observed |
| wr_addr_i | input | 32 | Address of the observed write |
| wr_ready_n_o | output | 1 | Active-low room indication; 1 when the queue is full |
| fill_start_i | input | 1 | Processor starts a bus cycle |
| fill_cacheable_i | input | 1 | Started cycle is a cacheable line fill |
| fill_addr_i | input | 32 | Address of the started cycle |
| xfer_done_n_i | input | 1 | Normal ready, active low; always final |
| burst_done_n_i | input | 1 | Burst ready, active low |
| burst_end_n_i | input | 1 | Burst-last indicator, active low |
| snoop_stb_n_o | output | 1 | Invalidate strobe to the processor, active low, registered |
| snoop_addr_o | output | 32 | Line address of the invalidate, registered |

## Verification
The bench sweeps the final-ready pulse across every slot of a four-entry tracked drain, using both the normal and burst forms. A design that gated in the wrong clock would show its gap one position off, and one that counted a non-last burst ready would lose throughput. Alternating-mode drains of one to four entries run with ready held active and the mode pin flipped after reset. A design that followed the bus or the live pin would issue in adjacent clocks. Collision runs compare a cacheable fill, a non-cacheable start and a fill already closed by ready: the first must reorder the queue, the other two must not. The queue is also stalled full and offered a fifth write, which must never appear as a strobe.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic {
    MODE_ALT   = 1'b0,
    MODE_TRACK = 1'b1
  } mode_e;

  // A transfer is finished by a normal ready, or by a burst ready in the last beat.
  function automatic logic xfer_final(input logic done_n, input logic bdone_n,
                                      input logic bend_n);
    return (!done_n) || (!bdone_n && !bend_n);
  endfunction

endpackage

// File: rtl/snp_queue.sv
module snp_queue #(
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_back,
  input  logic          push_front,
  input  logic [AW-1:0] din,
  input  logic          pop,
  output logic [AW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem   [DEPTH];
  logic [AW-1:0] shifted [DEPTH];
  logic [AW-1:0] mem_n [DEPTH];
  logic [CW-1:0] cnt, cnt_mid, cnt_n;
  logic          pop_ok, push_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign head    = mem[0];
  assign pop_ok  = pop && !empty;
  assign push_ok = (push_back || push_front) && !full;

  always_comb begin
    for (int i = 0; i < DEPTH - 1; i++) shifted[i] = pop_ok ? mem[i+1] : mem[i];
    shifted[DEPTH-1] = pop_ok ? '0 : mem[DEPTH-1];
    cnt_mid = pop_ok ? cnt - CW'(1) : cnt;
    for (int i = 0; i < DEPTH; i++) mem_n[i] = shifted[i];
    cnt_n = cnt_mid;
    if (push_ok) begin
      if (push_front) begin
        mem_n[0] = din;
        for (int i = 1; i < DEPTH; i++) mem_n[i] = shifted[i-1];
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (cnt_mid == CW'(i)) mem_n[i] = din;
      end
      cnt_n = cnt_mid + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt <= cnt_n;
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_n[i];
    end
  end

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

  // R2
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/snp_fill_track.sv
module snp_fill_track #(
  parameter int AW       = 32,
  parameter int LINE_LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cacheable,
  input  logic [AW-1:0] start_addr,
  input  logic          last_now,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_line,
  output logic          fill_open,
  output logic          hit
);
  localparam logic [AW-1:0] LMASK = {{(AW-LINE_LSB){1'b1}}, {LINE_LSB{1'b0}}};

  function automatic logic [AW-1:0] line_of(input logic [AW-1:0] a);
    return a & LMASK;
  endfunction

  logic [AW-1:0] fill_line;
  logic          open_ev;

  assign open_ev = start && cacheable;
  assign hit     = wr_valid && fill_open && (line_of(wr_line) == fill_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_open <= 1'b0;
      fill_line <= '0;
    end else if (open_ev) begin
      fill_open <= 1'b1;
      fill_line <= line_of(start_addr);
    end else if (last_now) begin
      fill_open <= 1'b0;
    end
  end

  // R7
  fill_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_ev |=> fill_open);

  // R7
  fill_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_now && !open_ev) |=> !fill_open);

endmodule

// File: rtl/snp_issue_gate.sv
module snp_issue_gate
  import snp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_i,
  input  logic  last_now,
  input  logic  empty,
  output logic  pop,
  output logic  stb_n,
  output mode_e mode_q
);
  logic slot_free;

  always_comb begin
    if (mode_q == MODE_TRACK) slot_free = !last_now;
    else                      slot_free = stb_n;
  end

  assign pop = !empty && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= mode_i ? MODE_TRACK : MODE_ALT;
      stb_n  <= 1'b1;
    end else begin
      stb_n  <= !pop;
    end
  end

  // R3
  alt_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ALT && !stb_n) |=> stb_n);

  // R5
  last_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TRACK && last_now) |=> stb_n);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));

endmodule

// File: rtl/snoop_inval_sched.sv
module snoop_inval_sched #(
  parameter int AW       = 32,
  parameter int DEPTH    = 4,
  parameter int LINE_LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_track_i,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          wr_ready_n_o,
  input  logic          fill_start_i,
  input  logic          fill_cacheable_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic          xfer_done_n_i,
  input  logic          burst_done_n_i,
  input  logic          burst_end_n_i,
  output logic          snoop_stb_n_o,
  output logic [AW-1:0] snoop_addr_o
);
  import snp_pkg::*;

  localparam logic [AW-1:0] LMASK = {{(AW-LINE_LSB){1'b1}}, {LINE_LSB{1'b0}}};

  logic          last_now;
  logic          hit, fill_open;
  logic          q_empty, q_full, pop;
  logic [AW-1:0] q_head, wr_line;
  mode_e         mode_q;

  assign last_now = xfer_final(xfer_done_n_i, burst_done_n_i, burst_end_n_i);
  assign wr_line  = wr_addr_i & LMASK;

  snp_fill_track #(.AW(AW), .LINE_LSB(LINE_LSB)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .start(fill_start_i), .cacheable(fill_cacheable_i), .start_addr(fill_addr_i),
    .last_now(last_now), .wr_valid(wr_valid_i), .wr_line(wr_line),
    .fill_open(fill_open), .hit(hit)
  );

  snp_queue #(.AW(AW), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push_back(wr_valid_i && !hit), .push_front(hit), .din(wr_line),
    .pop(pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  snp_issue_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_track_i), .last_now(last_now),
    .empty(q_empty), .pop(pop), .stb_n(snoop_stb_n_o), .mode_q(mode_q)
  );

  assign wr_ready_n_o = q_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   snoop_addr_o <= '0;
    else if (pop) snoop_addr_o <= q_head;
  end

  // R2
  aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_stb_n_o |-> (snoop_addr_o[LINE_LSB-1:0] == '0));

  // R8
  hit_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !q_full) |=> (q_head == $past(wr_line)));

  // R6
  ready_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready_n_o && !pop) |=> wr_ready_n_o);

endmodule

// File: tb/test_snoop_inval_sched.sv
module test_snoop_inval_sched;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, mode_i, wr_v, f_s, f_c, dn, bdn, ben;
  logic [AW-1:0] wr_a, f_a;
  logic          stb_n, wr_rdy_n;
  logic [AW-1:0] s_a;

  int tests = 0, fails = 0, cyc = 0, pcnt = 0;
  logic cur_mode = 1'b0, prev_low = 1'b0;
  logic [AW-1:0] plog_a [32];
  int            plog_c [32];

  snoop_inval_sched i_snoop_inval_sched (
    .clk(clk), .rst_n(rst_n), .mode_track_i(mode_i),
    .wr_valid_i(wr_v), .wr_addr_i(wr_a), .wr_ready_n_o(wr_rdy_n),
    .fill_start_i(f_s), .fill_cacheable_i(f_c), .fill_addr_i(f_a),
    .xfer_done_n_i(dn), .burst_done_n_i(bdn), .burst_end_n_i(ben),
    .snoop_stb_n_o(stb_n), .snoop_addr_o(s_a)
  );

  function automatic logic [AW-1:0] line(input logic [AW-1:0] a);
    return {a[AW-1:4], 4'h0};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic idle();
    wr_v = 1'b0; wr_a = '0; f_s = 1'b0; f_c = 1'b0; f_a = '0;
    dn = 1'b1; bdn = 1'b1; ben = 1'b1;
  endtask

  // One clock: inputs set before the call were sampled by the edge just passed.
  task automatic step();
    @(negedge clk);
    cyc++;
    if (!stb_n) begin
      if (!cur_mode) chk(!prev_low, "R3 adjacent strobe", 32'(prev_low), 32'd0);
      if (cur_mode)  chk(!(!dn || (!bdn && !ben)), "R5 strobe after final ready", 32'd0, 32'd1);
      chk(s_a[3:0] == 4'h0, "R2 alignment", 32'(s_a[3:0]), 32'd0);
      if (pcnt < 32) begin plog_a[pcnt] = s_a; plog_c[pcnt] = cyc; pcnt++; end
    end
    prev_low = !stb_n;
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; mode_i = m; cur_mode = m; idle();
    @(negedge clk); @(negedge clk);
    chk(stb_n == 1'b1, "R1 strobe in reset", 32'(stb_n), 32'd1);
    chk(wr_rdy_n == 1'b0, "R1 room in reset", 32'(wr_rdy_n), 32'd0);
    rst_n = 1'b1; cyc = 0; pcnt = 0; prev_low = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R3 / R9: alternating drains of 1..4 entries, ready held active, pin flipped
    for (int n = 1; n <= 4; n++) begin
      do_reset(1'b0);
      mode_i = 1'b1;
      for (int k = 0; k < n; k++) begin
        wr_v = 1'b1; wr_a = 32'h1000_0000 + 32'(k) * 32'h40 + 32'(k + 3); dn = 1'b0;
        step();
      end
      wr_v = 1'b0;
      repeat (10) step();
      chk(pcnt == n, "R9 pulse count alternating", 32'(pcnt), 32'(n));
      for (int k = 0; k < n; k++) begin
        chk(plog_a[k] == 32'h1000_0000 + 32'(k) * 32'h40, "R2 order alternating",
            plog_a[k], 32'h1000_0000 + 32'(k) * 32'h40);
        chk(plog_c[k] == 2 + 2 * k, "R3 alternating spacing", 32'(plog_c[k]), 32'(2 + 2 * k));
      end
    end

    // R6 / R4: fill queue while blocked, offer a fifth write, then drain
    do_reset(1'b1);
    for (int k = 0; k < 5; k++) begin
      dn = 1'b0; wr_v = 1'b1; wr_a = 32'h2000_0000 + 32'(k) * 32'h100 + 32'd5;
      step();
      if (k == 3) chk(wr_rdy_n == 1'b1, "R6 full flag", 32'(wr_rdy_n), 32'd1);
    end
    idle();
    repeat (8) step();
    chk(pcnt == 4, "R6 overflow write discarded", 32'(pcnt), 32'd4);
    for (int k = 0; k < 4; k++) begin
      chk(plog_a[k] == 32'h2000_0000 + 32'(k) * 32'h100, "R2 order tracked",
          plog_a[k], 32'h2000_0000 + 32'(k) * 32'h100);
      chk(plog_c[k] == 6 + k, "R4 back-to-back", 32'(plog_c[k]), 32'(6 + k));
    end
    chk(wr_rdy_n == 1'b0, "R6 room after drain", 32'(wr_rdy_n), 32'd0);

    // R5: final ready swept across each drain slot, both forms
    for (int g = 0; g < 4; g++) begin
      do_reset(1'b1);
      for (int k = 0; k < 4; k++) begin
        dn = 1'b0; wr_v = 1'b1; wr_a = 32'h4000_0000 + 32'(k) * 32'h10;
        step();
      end
      wr_v = 1'b0;
      for (int j = 0; j < 6; j++) begin
        if (j == g) begin
          if (g % 2 == 1) begin dn = 1'b1; bdn = 1'b0; ben = 1'b0; end
          else            begin dn = 1'b0; bdn = 1'b1; ben = 1'b1; end
        end else begin
          dn = 1'b1; bdn = 1'b0; ben = 1'b1;
        end
        step();
      end
      idle();
      chk(pcnt == 4, "R5 pulse count", 32'(pcnt), 32'd4);
      for (int i = 0; i < 4; i++) begin
        chk(plog_c[i] == 5 + ((i < g) ? i : i + 1), "R5 gap position",
            32'(plog_c[i]), 32'(5 + ((i < g) ? i : i + 1)));
        chk(plog_a[i] == 32'h4000_0000 + 32'(i) * 32'h10, "R2 order in sweep",
            plog_a[i], 32'h4000_0000 + 32'(i) * 32'h10);
      end
    end

    // R7 / R8: collision with open fill, non-cacheable start, closed fill
    for (int c = 0; c < 3; c++) begin
      logic [AW-1:0] exp_a [3];
      do_reset(1'b1);
      dn = 1'b0; wr_v = 1'b1; wr_a = 32'h3000_0040; step();
      wr_a = 32'h3000_0084; step();
      wr_v = 1'b0; f_s = 1'b1; f_c = (c != 0); f_a = 32'h3000_0004; step();
      f_s = 1'b0; f_c = 1'b0;
      if (c == 2) step();
      dn = 1'b1; wr_v = 1'b1; wr_a = 32'h3000_0008; step();
      idle();
      repeat (5) step();
      exp_a[0] = 32'h3000_0040;
      exp_a[1] = (c == 1) ? 32'h3000_0000 : 32'h3000_0080;
      exp_a[2] = (c == 1) ? 32'h3000_0080 : 32'h3000_0000;
      chk(pcnt == 3, "R7 pulse count", 32'(pcnt), 32'd3);
      for (int i = 0; i < 3; i++)
        chk(plog_a[i] == exp_a[i], (c == 1) ? "R8 hit to head" : "R7 no fill, no reorder",
            plog_a[i], exp_a[i]);
      chk(line(s_a) == s_a, "R2 last address aligned", s_a, line(s_a));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule